// File: doc/BRIEF.md
# DMA Channel Register and Interrupt Block

This block is the register front end of a multi-channel DMA engine. It decodes a simple 32-bit register bus and holds, for every channel, the descriptor-list address words, the two length words and, on receive channels, an enable bit and a bytes-per-row word. It also holds a global address-control bit. Channels come in pairs: each register instance serves one receive channel (even number) and one transmit channel (odd number). The descriptor engines that move the data sit outside this block. They receive a one-cycle start pulse per channel and return a one-cycle done pulse per channel.

Done pulses set per-channel status bits. Software clears these bits by writing ones. An enable mask selects which status bits count as pending, and one interrupt output is raised while any channel is pending. Transmit channels start when software writes the low word of their list address. Receive channels start when software writes a 1 to their enable bit.

Top module: `dmareg_top`

## Requirements
- R1: After a synchronous reset every register reads zero, `irq_o` is low and no start pulse is driven.
- R2: Instance i covers byte addresses 64*i to 64*i+63. The receive channel 2i has list-high at offset 0x00, list-low at 0x04, length at 0x0C, block length at 0x10, enable at 0x14 and bytes-per-row at 0x30. The transmit channel 2i+1 uses base 64*i+0x18 with list-high at +0x00, list-low at +0x04, block length at +0x0C and length at +0x14. All of these are full 32-bit read/write registers, except the enable register, which keeps only bit 0. A read raises `bus_rvalid` with the data one cycle after `bus_rd`.
- R3: A write to a transmit list-low register drives that channel's `start_o` bit high for exactly the following cycle. Writes to the other transmit registers give no pulse.
- R4: A write to a receive enable register with bit 0 set sets the enable and pulses that channel's `start_o` bit for one cycle. A write with bit 0 clear clears the enable and gives no pulse.
- R5: The address-control register at 0x34 keeps bit 0, and its other bits read zero.
- R6: The interrupt status register at 0x080000 has bit n for channel n. A done pulse sets bit n. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R7: When a done pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R8: The interrupt enable register at 0x080008 is read/write with one bit per channel. The pending register at 0x080004 is read-only and reads status AND enable. Writes to it change nothing.
- R9: `irq_o` is high exactly when status AND enable is nonzero, and it updates on the same clock edge as the status and enable registers. Writing zero to the enable register drops it.
- R10: Reads of any address that is not listed above return zero, and writes to such addresses change no register. This includes offset 0x34 in instances other than 0 and instances at or beyond the channel count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| done_i | input | 2*NUM_INST | Per-channel transfer-done pulses |
| start_o | output | 2*NUM_INST | Per-channel one-cycle start pulses |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench drives a done pulse and a clearing write at the same status bit in the same cycle. A design that lets the clear win would lose a completion and read the bit as zero. It also writes enable values with bit 0 clear and writes the transmit high word. A design that triggers on any write to these registers would emit stray start pulses. The bench probes the holes inside each instance, offset 0x34 in nonzero instances, the instance just past the last one and the address just past the enable register. A decoder that only partly decodes the address would alias these onto live registers, and that shows up on readback. A write to the read-only pending view is made to confirm it leaves status and enable untouched.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

  typedef enum logic [2:0] {
    SL_LHI = 3'd0,
    SL_LLO = 3'd1,
    SL_LEN = 3'd2,
    SL_BLK = 3'd3,
    SL_EN  = 3'd4,
    SL_ROW = 3'd5
  } slot_e;

  // byte offsets inside one 64-byte instance
  localparam logic [5:0] RX_LHI = 6'h00;
  localparam logic [5:0] RX_LLO = 6'h04;
  localparam logic [5:0] RX_LEN = 6'h0C;
  localparam logic [5:0] RX_BLK = 6'h10;
  localparam logic [5:0] RX_EN  = 6'h14;
  localparam logic [5:0] RX_ROW = 6'h30;
  localparam logic [5:0] TX_LHI = 6'h18;
  localparam logic [5:0] TX_LLO = 6'h1C;
  localparam logic [5:0] TX_BLK = 6'h24;
  localparam logic [5:0] TX_LEN = 6'h2C;
  localparam logic [5:0] ACR_OFF = 6'h34;

  localparam logic [31:0] ISR_ADDR = 32'h0008_0000;
  localparam logic [31:0] IPR_ADDR = 32'h0008_0004;
  localparam logic [31:0] IER_ADDR = 32'h0008_0008;

endpackage

// File: rtl/dmareg_dec.sv
module dmareg_dec
  import dmareg_pkg::*;
#(
  parameter int NUM_INST = 4,
  parameter int ADDR_W   = 20,
  localparam int INST_W  = (NUM_INST > 1) ? $clog2(NUM_INST) : 1,
  localparam int CH_W    = INST_W + 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_ch_o,
  output logic [CH_W-1:0]   ch_o,
  output slot_e             slot_o,
  output logic              hit_acr_o,
  output logic              hit_isr_o,
  output logic              hit_ipr_o,
  output logic              hit_ier_o
);

  logic [ADDR_W-7:0] upper;
  logic [5:0]        off;
  logic [INST_W-1:0] inst;
  logic              inst_ok;

  assign upper   = addr_i[ADDR_W-1:6];
  assign off     = addr_i[5:0];
  assign inst    = addr_i[6 +: INST_W];
  assign inst_ok = (upper < (ADDR_W-6)'(NUM_INST));

  always_comb begin
    hit_ch_o  = 1'b0;
    ch_o      = '0;
    slot_o    = SL_LHI;
    hit_acr_o = 1'b0;
    if (inst_ok) begin
      case (off)
        RX_LHI: begin hit_ch_o = 1'b1; ch_o = {inst, 1'b0}; slot_o = SL_LHI; end
        RX_LLO: begin hit_ch_o = 1'b1; ch_o = {inst, 1'b0}; slot_o = SL_LLO; end
        RX_LEN: begin hit_ch_o = 1'b1; ch_o = {inst, 1'b0}; slot_o = SL_LEN; end
        RX_BLK: begin hit_ch_o = 1'b1; ch_o = {inst, 1'b0}; slot_o = SL_BLK; end
        RX_EN:  begin hit_ch_o = 1'b1; ch_o = {inst, 1'b0}; slot_o = SL_EN;  end
        RX_ROW: begin hit_ch_o = 1'b1; ch_o = {inst, 1'b0}; slot_o = SL_ROW; end
        TX_LHI: begin hit_ch_o = 1'b1; ch_o = {inst, 1'b1}; slot_o = SL_LHI; end
        TX_LLO: begin hit_ch_o = 1'b1; ch_o = {inst, 1'b1}; slot_o = SL_LLO; end
        TX_BLK: begin hit_ch_o = 1'b1; ch_o = {inst, 1'b1}; slot_o = SL_BLK; end
        TX_LEN: begin hit_ch_o = 1'b1; ch_o = {inst, 1'b1}; slot_o = SL_LEN; end
        ACR_OFF: hit_acr_o = (upper == '0);
        default: ;
      endcase
    end
  end

  assign hit_isr_o = (addr_i == ISR_ADDR[ADDR_W-1:0]);
  assign hit_ipr_o = (addr_i == IPR_ADDR[ADDR_W-1:0]);
  assign hit_ier_o = (addr_i == IER_ADDR[ADDR_W-1:0]);

endmodule

// File: rtl/dmareg_chan.sv
module dmareg_chan
  import dmareg_pkg::*;
#(
  parameter bit IS_RX = 1'b1,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  slot_e         slot_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          start_o
);

  // list-high, list-low, length, block length
  logic [DW-1:0] base_q [4];
  logic          start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 4; k++) base_q[k] <= '0;
    end else if (wr_i && (slot_i inside {SL_LHI, SL_LLO, SL_LEN, SL_BLK})) begin
      base_q[slot_i[1:0]] <= wdata_i;
    end
  end

  generate
    if (IS_RX) begin : g_rx
      logic          en_q;
      logic [DW-1:0] row_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          en_q    <= 1'b0;
          row_q   <= '0;
          start_q <= 1'b0;
        end else begin
          start_q <= wr_i && (slot_i == SL_EN) && wdata_i[0];
          if (wr_i && (slot_i == SL_EN))  en_q  <= wdata_i[0];
          if (wr_i && (slot_i == SL_ROW)) row_q <= wdata_i;
        end
      end

      always_comb begin
        case (slot_i)
          SL_EN:   rdata_o = DW'(en_q);
          SL_ROW:  rdata_o = row_q;
          default: rdata_o = base_q[slot_i[1:0]];
        endcase
      end

      // R4
      en_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i && slot_i == SL_EN && !wdata_i[0]) |=> (!start_q && !en_q));
      // R4
      en_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i && slot_i == SL_EN && wdata_i[0]) |=> (start_q && en_q));
    end else begin : g_tx
      always_ff @(posedge clk) begin
        if (rst) start_q <= 1'b0;
        else     start_q <= wr_i && (slot_i == SL_LLO);
      end

      always_comb begin
        if (slot_i inside {SL_EN, SL_ROW}) rdata_o = '0;
        else                               rdata_o = base_q[slot_i[1:0]];
      end

      // R3
      tx_nostart_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i && slot_i != SL_LLO) |=> !start_q);
      // R3
      tx_start_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i && slot_i == SL_LLO) |=> start_q);
    end
  endgenerate

  assign start_o = start_q;

  // R3
  start_cause_chk: assert property (@(posedge clk) disable iff (rst)
    start_q |-> $past(wr_i));

endmodule

// File: rtl/dmareg_irq.sv
module dmareg_irq #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] done_i,
  input  logic              isr_wr_i,
  input  logic              ier_wr_i,
  input  logic [NUM_CH-1:0] wdata_i,
  output logic [NUM_CH-1:0] status_o,
  output logic [NUM_CH-1:0] enable_o,
  output logic [NUM_CH-1:0] pending_o,
  output logic              irq_o
);

  logic [NUM_CH-1:0] status_q, status_d;
  logic [NUM_CH-1:0] enable_q, enable_d;
  logic              irq_q;

  always_comb begin
    // clear first, then set, so a same-cycle done pulse survives
    status_d = (status_q & ~(isr_wr_i ? wdata_i : '0)) | done_i;
    enable_d = ier_wr_i ? wdata_i : enable_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      enable_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      enable_q <= enable_d;
      irq_q    <= |(status_d & enable_d);
    end
  end

  assign status_o  = status_q;
  assign enable_o  = enable_q;
  assign pending_o = status_q & enable_q;
  assign irq_o     = irq_q;

  // R6
  done_set_chk: assert property (@(posedge clk) disable iff (rst)
    (|done_i) |=> ((status_q & $past(done_i)) == $past(done_i)));
  // R6
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    isr_wr_i |=> ((status_q & $past(wdata_i & ~done_i)) == '0));
  // R9
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q == (|(status_q & enable_q)));
  // R9
  mask_all_chk: assert property (@(posedge clk) disable iff (rst)
    (ier_wr_i && wdata_i == '0) |=> !irq_q);

endmodule

// File: rtl/dmareg_top.sv
module dmareg_top
  import dmareg_pkg::*;
#(
  parameter int NUM_INST = 4,
  parameter int ADDR_W   = 20,
  parameter int DW       = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DW-1:0]         bus_wdata,
  output logic [DW-1:0]         bus_rdata,
  output logic                  bus_rvalid,
  input  logic [2*NUM_INST-1:0] done_i,
  output logic [2*NUM_INST-1:0] start_o,
  output logic                  irq_o
);

  localparam int NUM_CH = 2 * NUM_INST;
  localparam int INST_W = (NUM_INST > 1) ? $clog2(NUM_INST) : 1;
  localparam int CH_W   = INST_W + 1;

  logic            hit_ch, hit_acr, hit_isr, hit_ipr, hit_ier;
  logic [CH_W-1:0] ch_sel;
  slot_e           slot;

  dmareg_dec #(
    .NUM_INST (NUM_INST),
    .ADDR_W   (ADDR_W)
  ) u_dec (
    .addr_i    (bus_addr),
    .hit_ch_o  (hit_ch),
    .ch_o      (ch_sel),
    .slot_o    (slot),
    .hit_acr_o (hit_acr),
    .hit_isr_o (hit_isr),
    .hit_ipr_o (hit_ipr),
    .hit_ier_o (hit_ier)
  );

  logic [DW-1:0] ch_rdata [NUM_CH];

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dmareg_chan #(
        .IS_RX ((c % 2) == 0),
        .DW    (DW)
      ) u_chan (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (bus_wr && hit_ch && (ch_sel == CH_W'(c))),
        .slot_i  (slot),
        .wdata_i (bus_wdata),
        .rdata_o (ch_rdata[c]),
        .start_o (start_o[c])
      );
    end
  endgenerate

  logic acr_q;
  always_ff @(posedge clk) begin
    if (rst)                    acr_q <= 1'b0;
    else if (bus_wr && hit_acr) acr_q <= bus_wdata[0];
  end

  logic [NUM_CH-1:0] status, enable, pending;

  dmareg_irq #(
    .NUM_CH (NUM_CH)
  ) u_irq (
    .clk       (clk),
    .rst       (rst),
    .done_i    (done_i),
    .isr_wr_i  (bus_wr && hit_isr),
    .ier_wr_i  (bus_wr && hit_ier),
    .wdata_i   (bus_wdata[NUM_CH-1:0]),
    .status_o  (status),
    .enable_o  (enable),
    .pending_o (pending),
    .irq_o     (irq_o)
  );

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit_ch)       rd_mux = ch_rdata[ch_sel];
    else if (hit_acr) rd_mux = DW'(acr_q);
    else if (hit_isr) rd_mux = DW'(status);
    else if (hit_ipr) rd_mux = DW'(pending);
    else if (hit_ier) rd_mux = DW'(enable);
  end

  logic [DW-1:0] rdata_q;
  logic          rvalid_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rdata_q  <= bus_rd ? rd_mux : '0;
      rvalid_q <= bus_rd;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (start_o == '0 && !irq_o && !bus_rvalid));
  // R2
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
  // R2
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (!bus_rvalid && bus_rdata == '0));
  // R8
  ipr_ro_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && hit_ipr && done_i == '0) |=> ($stable(status) && $stable(enable)));

endmodule

// File: tb/dmareg_top_tb.sv
`timescale 1ns/1ps
module dmareg_top_tb;

  localparam int NI  = 4;
  localparam int NCH = 2 * NI;
  localparam int AW  = 20;

  logic           clk = 1'b0;
  logic           rst;
  logic           bus_wr, bus_rd;
  logic [AW-1:0]  bus_addr;
  logic [31:0]    bus_wdata;
  logic [31:0]    bus_rdata;
  logic           bus_rvalid;
  logic [NCH-1:0] done_i;
  logic [NCH-1:0] start_o;
  logic           irq_o;

  always #5 clk = ~clk;

  dmareg_top #(.NUM_INST(NI), .ADDR_W(AW), .DW(32)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .done_i(done_i), .start_o(start_o), .irq_o(irq_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // reference model
  logic [31:0]    m_ch [NCH][6];
  logic           m_acr;
  logic [NCH-1:0] m_st, m_en;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // kind: 0 unmapped, 1 channel, 2 acr, 3 status, 4 pending, 5 enable
  function automatic void decode(input logic [AW-1:0] a, output int kind,
                                 output int ch, output int sl);
    int inst, off;
    kind = 0; ch = 0; sl = 0;
    if (a < AW'(NI * 64)) begin
      inst = int'(a) / 64;
      off  = int'(a) % 64;
      case (off)
        'h00: begin kind = 1; ch = 2*inst;   sl = 0; end
        'h04: begin kind = 1; ch = 2*inst;   sl = 1; end
        'h0C: begin kind = 1; ch = 2*inst;   sl = 2; end
        'h10: begin kind = 1; ch = 2*inst;   sl = 3; end
        'h14: begin kind = 1; ch = 2*inst;   sl = 4; end
        'h30: begin kind = 1; ch = 2*inst;   sl = 5; end
        'h18: begin kind = 1; ch = 2*inst+1; sl = 0; end
        'h1C: begin kind = 1; ch = 2*inst+1; sl = 1; end
        'h2C: begin kind = 1; ch = 2*inst+1; sl = 2; end
        'h24: begin kind = 1; ch = 2*inst+1; sl = 3; end
        'h34: if (inst == 0) kind = 2;
        default: ;
      endcase
    end else if (a == 20'h80000) kind = 3;
    else if (a == 20'h80004) kind = 4;
    else if (a == 20'h80008) kind = 5;
  endfunction

  function automatic logic [31:0] model_read(input logic [AW-1:0] a);
    int kind, ch, sl;
    decode(a, kind, ch, sl);
    case (kind)
      1: return m_ch[ch][sl];
      2: return {31'b0, m_acr};
      3: return 32'(m_st);
      4: return 32'(m_st & m_en);
      5: return 32'(m_en);
      default: return 32'h0;
    endcase
  endfunction

  function automatic string kind_req(input logic [AW-1:0] a);
    int kind, ch, sl;
    decode(a, kind, ch, sl);
    case (kind)
      1: return "R2";
      2: return "R5";
      3: return "R6";
      4: return "R8";
      5: return "R8";
      default: return "R10";
    endcase
  endfunction

  // one bus cycle; checks start, read data and irq after the edge
  task automatic step(bit wr, bit rd, logic [AW-1:0] a, logic [31:0] d,
                      logic [NCH-1:0] dn);
    int kind, ch, sl;
    logic [31:0]    exp_rd;
    logic [NCH-1:0] exp_start;
    string rq;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; done_i = dn;
    exp_rd = model_read(a);
    rq = kind_req(a);
    decode(a, kind, ch, sl);
    exp_start = '0;
    if (wr && kind == 1) begin
      if ((ch % 2) == 1 && sl == 1) exp_start[ch] = 1'b1;
      if ((ch % 2) == 0 && sl == 4 && d[0]) exp_start[ch] = 1'b1;
    end
    @(posedge clk);
    #1;
    // model update: writes, then clear-before-set on status (R7)
    if (wr) begin
      case (kind)
        1: m_ch[ch][sl] = (sl == 4) ? {31'b0, d[0]} : d;
        2: m_acr = d[0];
        3: m_st = m_st & ~d[NCH-1:0];
        5: m_en = d[NCH-1:0];
        default: ;
      endcase
    end
    m_st = m_st | dn;
    chk(start_o == exp_start, "R3/R4 start", 32'(start_o), 32'(exp_start));
    if (rd) chk(bus_rvalid && bus_rdata == exp_rd, rq, bus_rdata, exp_rd);
    chk(irq_o == (|(m_st & m_en)), "R9 irq", 32'(irq_o), 32'(|(m_st & m_en)));
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    step(1'b1, 1'b0, a, d, '0);
  endtask
  task automatic rd(logic [AW-1:0] a);
    step(1'b0, 1'b1, a, 32'h0, '0);
  endtask

  function automatic logic [AW-1:0] chan_addr(int ch, int sl);
    logic [AW-1:0] base;
    base = AW'((ch / 2) * 64);
    if ((ch % 2) == 0) begin
      case (sl)
        0: return base + 20'h00;
        1: return base + 20'h04;
        2: return base + 20'h0C;
        3: return base + 20'h10;
        4: return base + 20'h14;
        default: return base + 20'h30;
      endcase
    end else begin
      case (sl)
        0: return base + 20'h18;
        1: return base + 20'h1C;
        2: return base + 20'h2C;
        default: return base + 20'h24;
      endcase
    end
  endfunction

  function automatic logic [AW-1:0] rand_addr();
    int r, ch;
    r = int'($urandom % 10);
    if (r < 6) begin
      ch = int'($urandom % NCH);
      return chan_addr(ch, int'($urandom % (((ch % 2) == 0) ? 6 : 4)));
    end
    if (r == 6) return 20'h34;
    if (r == 7) return 20'h80000 + AW'(4 * ($urandom % 3));
    case ($urandom % 9)
      0: return 20'h08;
      1: return 20'h20;
      2: return 20'h28;
      3: return 20'h38;
      4: return 20'h3C;
      5: return 20'h74;
      6: return AW'(NI * 64);
      7: return 20'h7FFFC;
      default: return 20'h8000C;
    endcase
  endfunction

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < NCH; c++) for (int s = 0; s < 6; s++) m_ch[c][s] = '0;
    m_acr = 1'b0; m_st = '0; m_en = '0;
    rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0; done_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset state
    chk(start_o == '0 && !irq_o && !bus_rvalid, "R1 outputs", 32'(start_o), 32'h0);
    rd(20'h0); rd(20'h1C); rd(20'h34); rd(20'h80000); rd(20'h80008); rd(20'h30);

    // R2: fill every channel register and read back
    for (int c = 0; c < NCH; c++)
      for (int s = 0; s < (((c % 2) == 0) ? 6 : 4); s++)
        wr(chan_addr(c, s), {8'(c), 8'(s), 16'hA5C3});
    for (int c = 0; c < NCH; c++)
      for (int s = 0; s < (((c % 2) == 0) ? 6 : 4); s++)
        rd(chan_addr(c, s));

    // R3: high word gives no start, low word gives exactly one
    wr(20'h58, 32'h1234); wr(20'h5C, 32'h8000); rd(20'h5C);
    // R4: enable set, clear, clear with other bits set
    wr(20'h94, 32'h1); rd(20'h94); wr(20'h94, 32'h0); rd(20'h94);
    wr(20'h94, 32'hFFFF_FFFE); rd(20'h94);
    // R5: only bit 0 kept
    wr(20'h34, 32'hFFFF_FFFF); rd(20'h34); wr(20'h34, 32'h2); rd(20'h34);

    // R6, R8, R9: done sets status, enable gates irq
    step(1'b0, 1'b0, '0, '0, 8'h04);
    rd(20'h80000); rd(20'h80004);
    wr(20'h80008, 32'h04); rd(20'h80004);
    // R8: write to pending ignored
    wr(20'h80004, 32'hFFFF_FFFF); rd(20'h80000); rd(20'h80008);
    // R6: zero write leaves bits
    wr(20'h80000, 32'h0); rd(20'h80000);
    // R7: clear and done in the same cycle -> set wins
    step(1'b1, 1'b0, 20'h80000, 32'h04, 8'h04); rd(20'h80000);
    // R6: all ones clears everything
    step(1'b0, 1'b0, '0, '0, 8'hA1);
    wr(20'h80000, 32'hFFFF_FFFF); rd(20'h80000);
    // R9: masking with zero drops irq
    wr(20'h80008, 32'hFF); step(1'b0, 1'b0, '0, '0, 8'h10);
    wr(20'h80008, 32'h0); rd(20'h80004);

    // R10: unmapped writes and reads, then check neighbours untouched
    wr(20'h08, 32'hDEAD_BEEF); rd(20'h08);
    wr(20'h74, 32'h1); rd(20'h74);
    wr(AW'(NI * 64), 32'hFFFF); rd(AW'(NI * 64));
    wr(20'h8000C, 32'hFF); rd(20'h8000C); rd(20'h80008);
    rd(20'h04); rd(20'h0C); rd(20'h34); rd(20'h40);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0]  a;
      logic [NCH-1:0] dn;
      a  = rand_addr();
      dn = (($urandom % 4) == 0) ? NCH'($urandom) : '0;
      if (($urandom % 2) == 0) step(1'b1, 1'b0, a, $urandom, dn);
      else                     step(1'b0, 1'b1, a, 32'h0, dn);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule